// File: doc/BRIEF.md
# USB End-of-Packet Detector

This block watches the synchronized USB line state, presented as three flags (single-ended zero, J, K), and acts only on the clock cycles where a sample enable is high. It follows a single-ended-zero run from its first sample and decides, when the line leaves SE0, whether that run ended a packet. A run that is shorter than the minimum duration for the selected bus speed is treated as a glitch and discarded. A run that is long enough always produces an end-of-packet strobe, so the downstream logic can look for the next packet. When the sample after the run is not a J state, the block also raises a possible-bad-end status.

The current state is exported as a fixed 3-bit code so a debug port can trace the sequence. The minimum SE0 duration is given in nanoseconds for each speed. It is converted at elaboration into a sample count, using the sample period parameter, and a speed select input picks which count applies.

Top module: `usb_eop_detector`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the state code is 3'b000 and both strobes are low.
- R2: The state codes are: idle 3'b000, first SE0 sample 3'b001, second SE0 sample 3'b010, third or later SE0 sample 3'b110, good end 3'b011, bad end 3'b111.
- R3: A run of SE0 samples moves the state from idle through 001 and 010 to 110, and the state stays 110 for as long as SE0 is sampled.
- R4: At full speed (low_speed = 0), with the default parameters, a run of fewer than 3 SE0 samples that is followed by a non-SE0 sample returns the state to 000 and raises no strobe.
- R5: At low speed (low_speed = 1), with the default parameters, the minimum run is 15 SE0 samples. A run of 14 samples followed by J raises no strobe, and a run of 15 samples followed by J raises the end strobe.
- R6: When a run of at least the minimum length is followed by a J sample, the state becomes 3'b011, eop_stb pulses, and bad_eop_stb stays low.
- R7: When a run of at least the minimum length is followed by a sample that is not J, the state becomes 3'b111 and both eop_stb and bad_eop_stb pulse.
- R8: Each strobe is high for exactly one clock cycle, in the cycle where the state first shows 011 or 111. The state returns to 000 at the next sample, whatever the line shows.
- R9: On cycles where sample_en is low, the state and the SE0 run length do not change, whatever the line inputs do.
- R10: Line flags are ranked: SE0 wins over J, and J wins over K. A sample with none of the flags set counts as not J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Line is sampled on this cycle |
| se0_in | input | 1 | Line shows single-ended zero |
| j_in | input | 1 | Line shows J |
| k_in | input | 1 | Line shows K |
| low_speed | input | 1 | Selects the low-speed minimum SE0 duration |
| eop_stb | output | 1 | One-cycle pulse when a packet end is declared |
| bad_eop_stb | output | 1 | One-cycle pulse when the end lacked a J state |
| state_code | output | 3 | Current state code for debug |

## Verification
The hardest cases to reach are the ones on the edge of the length limit. At low speed the run must be exactly one sample short or exactly long enough, and the line inputs must be changing while sample_en is low, with no effect on the count. The stimulus builds each sample with a task. The task holds SE0 for a chosen number of samples and, in the idle cycles between samples, drives the line to disturbing values (SE0 together with J). These runs are mixed with samples on every clock, with SE0 resumed right after an end state, and with samples where several flags are set at once. A behavioural model tracks the run length as an integer and is compared with the outputs on every clock.

// File: rtl/usb_eop_pkg.sv
package usb_eop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'b000,
        ST_SE0_ONE  = 3'b001,
        ST_SE0_TWO  = 3'b010,
        ST_GOOD_END = 3'b011,
        ST_SE0_MANY = 3'b110,
        ST_BAD_END  = 3'b111
    } eop_state_e;

    typedef enum logic [1:0] {
        LN_SE0  = 2'd0,
        LN_J    = 2'd1,
        LN_K    = 2'd2,
        LN_NONE = 2'd3
    } line_e;

    typedef struct packed {
        logic  tick;
        line_e ln;
    } line_smp_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic in_se0_run(input eop_state_e s);
        return (s == ST_SE0_ONE) || (s == ST_SE0_TWO) || (s == ST_SE0_MANY);
    endfunction

    function automatic logic is_end_state(input eop_state_e s);
        return (s == ST_GOOD_END) || (s == ST_BAD_END);
    endfunction

endpackage

// File: rtl/usb_eop_line_classify.sv
module usb_eop_line_classify
    import usb_eop_pkg::*;
(
    input  logic      sample_en,
    input  logic      se0_in,
    input  logic      j_in,
    input  logic      k_in,
    output line_smp_t smp
);

    line_e ln_c;

    // Ranked decode: SE0 first, then J, then K
    always_comb begin
        if (se0_in)      ln_c = LN_SE0;
        else if (j_in)   ln_c = LN_J;
        else if (k_in)   ln_c = LN_K;
        else             ln_c = LN_NONE;
    end

    assign smp.tick = sample_en;
    assign smp.ln   = ln_c;

    always_comb begin
        if (se0_in) a_r10_se0_first: assert (smp.ln == LN_SE0);
        if (!se0_in && j_in) a_r10_j_over_k: assert (smp.ln == LN_J);
    end

endmodule

// File: rtl/usb_eop_se0_timer.sv
module usb_eop_se0_timer
    import usb_eop_pkg::*;
#(
    parameter int unsigned FS_LIMIT = 3,
    parameter int unsigned LS_LIMIT = 15,
    localparam int unsigned MAX_LIMIT = (FS_LIMIT > LS_LIMIT) ? FS_LIMIT : LS_LIMIT,
    localparam int unsigned CNT_W = $clog2(MAX_LIMIT + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  line_smp_t smp,
    input  logic      track,
    input  logic      low_speed,
    output logic      long_enough
);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] limit_sel;
    logic             at_cap;

    generate
        if (FS_LIMIT == LS_LIMIT) begin : g_one_limit
            assign limit_sel = CNT_W'(FS_LIMIT);
        end else begin : g_two_limits
            assign limit_sel = low_speed ? CNT_W'(LS_LIMIT) : CNT_W'(FS_LIMIT);
        end
    endgenerate

    assign at_cap = (run_cnt == CNT_W'(MAX_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (smp.tick) begin
            if (track && smp.ln == LN_SE0) begin
                if (!at_cap) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign long_enough = (run_cnt >= limit_sel);

    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        !smp.tick |=> $stable(run_cnt));
    a_r4_count_clear: assert property (@(posedge clk) disable iff (rst)
        smp.tick && smp.ln != LN_SE0 |=> run_cnt == '0);

endmodule

// File: rtl/usb_eop_fsm.sv
module usb_eop_fsm
    import usb_eop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_smp_t  smp,
    input  logic       long_enough,
    output logic       track,
    output eop_state_e state,
    output logic       eop_stb,
    output logic       bad_eop_stb
);

    eop_state_e nxt;
    eop_state_e run_exit;

    // Where an SE0 run goes when the line leaves SE0
    always_comb begin
        if (!long_enough)          run_exit = ST_IDLE;
        else if (smp.ln == LN_J)   run_exit = ST_GOOD_END;
        else                       run_exit = ST_BAD_END;
    end

    always_comb begin
        nxt = state;
        if (smp.tick) begin
            unique case (state)
                ST_IDLE:     nxt = (smp.ln == LN_SE0) ? ST_SE0_ONE  : ST_IDLE;
                ST_SE0_ONE:  nxt = (smp.ln == LN_SE0) ? ST_SE0_TWO  : run_exit;
                ST_SE0_TWO:  nxt = (smp.ln == LN_SE0) ? ST_SE0_MANY : run_exit;
                ST_SE0_MANY: nxt = (smp.ln == LN_SE0) ? ST_SE0_MANY : run_exit;
                ST_GOOD_END: nxt = ST_IDLE;
                ST_BAD_END:  nxt = ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    assign track = !is_end_state(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            eop_stb     <= 1'b0;
            bad_eop_stb <= 1'b0;
        end else begin
            state       <= nxt;
            eop_stb     <= smp.tick && is_end_state(nxt);
            bad_eop_stb <= smp.tick && (nxt == ST_BAD_END);
        end
    end

    a_r9_state_hold: assert property (@(posedge clk) disable iff (rst)
        !smp.tick |=> $stable(state));
    a_r8_back_to_idle: assert property (@(posedge clk) disable iff (rst)
        smp.tick && is_end_state(state) |=> state == ST_IDLE);
    a_r8_one_clock: assert property (@(posedge clk) disable iff (rst)
        eop_stb |=> !eop_stb);
    a_r7_bad_has_eop: assert property (@(posedge clk) disable iff (rst)
        bad_eop_stb |-> eop_stb && state == ST_BAD_END);
    a_r6_strobe_state: assert property (@(posedge clk) disable iff (rst)
        eop_stb |-> is_end_state(state) && $changed(state));
    a_r4_short_quiet: assert property (@(posedge clk) disable iff (rst)
        smp.tick && in_se0_run(state) && smp.ln != LN_SE0 && !long_enough |=> !eop_stb && state == ST_IDLE);
    a_r3_hold_many: assert property (@(posedge clk) disable iff (rst)
        smp.tick && state == ST_SE0_MANY && smp.ln == LN_SE0 |=> state == ST_SE0_MANY);

endmodule

// File: rtl/usb_eop_detector.sv
module usb_eop_detector
    import usb_eop_pkg::*;
#(
    parameter int unsigned SAMPLE_PS = 20833,
    parameter int unsigned FS_MIN_NS = 60,
    parameter int unsigned LS_MIN_NS = 300,
    localparam int unsigned FS_LIMIT = at_least_one(ceil_div(FS_MIN_NS * 1000, SAMPLE_PS)),
    localparam int unsigned LS_LIMIT = at_least_one(ceil_div(LS_MIN_NS * 1000, SAMPLE_PS))
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic       se0_in,
    input  logic       j_in,
    input  logic       k_in,
    input  logic       low_speed,
    output logic       eop_stb,
    output logic       bad_eop_stb,
    output logic [2:0] state_code
);

    line_smp_t  smp;
    logic       track;
    logic       long_enough;
    eop_state_e state;

    usb_eop_line_classify u_classify (
        .sample_en (sample_en),
        .se0_in    (se0_in),
        .j_in      (j_in),
        .k_in      (k_in),
        .smp       (smp)
    );

    usb_eop_se0_timer #(
        .FS_LIMIT (FS_LIMIT),
        .LS_LIMIT (LS_LIMIT)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .track       (track),
        .low_speed   (low_speed),
        .long_enough (long_enough)
    );

    usb_eop_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .long_enough (long_enough),
        .track       (track),
        .state       (state),
        .eop_stb     (eop_stb),
        .bad_eop_stb (bad_eop_stb)
    );

    assign state_code = state;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> state_code == 3'b000 && !eop_stb && !bad_eop_stb);

endmodule

// File: tb/sim_usb_eop_detector.sv
module sim_usb_eop_detector;

    localparam int SAMPLE_PS = 20833;
    localparam int FS_LIM = (60000 + SAMPLE_PS - 1) / SAMPLE_PS;
    localparam int LS_LIM = (300000 + SAMPLE_PS - 1) / SAMPLE_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic se0_in = 1'b0, j_in = 1'b1, k_in = 1'b0, low_speed = 1'b0;
    logic eop_stb, bad_eop_stb;
    logic [2:0] state_code;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model state
    int ph = 0, run = 0;
    bit m_eop = 0, m_bad = 0;

    always #4 clk = ~clk;

    usb_eop_detector u0 (
        .clk(clk), .rst(rst), .sample_en(sample_en), .se0_in(se0_in),
        .j_in(j_in), .k_in(k_in), .low_speed(low_speed),
        .eop_stb(eop_stb), .bad_eop_stb(bad_eop_stb), .state_code(state_code)
    );

    function automatic logic [2:0] code_of(int p);
        case (p)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b010;
            3: return 3'b110;
            4: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    always @(posedge clk) begin
        m_eop = 0; m_bad = 0;
        if (rst) begin
            ph = 0; run = 0;
        end else if (sample_en) begin
            bit s0, isj;
            int lim;
            s0  = se0_in;
            isj = !se0_in && j_in;
            lim = low_speed ? LS_LIM : FS_LIM;
            if (ph == 0) begin
                if (s0) begin ph = 1; run = 1; end
            end else if (ph >= 4) begin
                ph = 0; run = 0;
            end else if (s0) begin
                if (run < 1000) run++;
                ph = (ph == 1) ? 2 : 3;
            end else if (run >= lim) begin
                ph = isj ? 4 : 5; m_eop = 1; m_bad = !isj; run = 0;
            end else begin
                ph = 0; run = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (state_code !== code_of(ph) || eop_stb !== m_eop || bad_eop_stb !== m_bad) begin
                n_bad++;
                $display("FAIL %s t=%0t actual state=%b eop=%b bad=%b expected state=%b eop=%b bad=%b",
                         cur_req, $time, state_code, eop_stb, bad_eop_stb, code_of(ph), m_eop, m_bad);
            end
        end
    end

    // one sample, then gap idle cycles with disturbing inputs (R9)
    task automatic put(input bit s0, input bit j, input bit k, input int gap);
        @(negedge clk);
        se0_in = s0; j_in = j; k_in = k; sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        for (int g = 0; g < gap; g++) begin
            se0_in = (g % 2 == 0); j_in = 1'b1; k_in = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic se0_run(input int n, input int gap);
        for (int i = 0; i < n; i++) put(1, 0, 0, gap);
    endtask

    task automatic finish_up();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        n_cmp++;
        if (state_code !== 3'b000 || eop_stb !== 1'b0 || bad_eop_stb !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 actual=%b%b%b expected=00000", state_code, eop_stb, bad_eop_stb);
        end
        rst = 1'b0;
        put(0, 1, 0, 2);
        put(0, 1, 0, 0);

        cur_req = "R4 short SE0 at full speed";
        se0_run(2, 2); put(0, 1, 0, 2);
        se0_run(1, 0); put(0, 0, 1, 1);

        cur_req = "R6 good end at full speed";
        se0_run(3, 2); put(0, 1, 0, 2); put(0, 1, 0, 1);

        cur_req = "R3 long SE0 hold and R2 codes";
        se0_run(8, 1); put(0, 1, 0, 0); put(0, 1, 0, 0);

        cur_req = "R7 K after SE0";
        se0_run(3, 0); put(0, 0, 1, 0); put(0, 1, 0, 0);

        cur_req = "R10 no flag after SE0 and SE0 beats J";
        put(1, 1, 0, 1); put(1, 1, 1, 1); put(1, 0, 0, 1); put(0, 0, 0, 1); put(0, 1, 0, 0);

        cur_req = "R10 J beats K";
        se0_run(4, 0); put(0, 1, 1, 0); put(0, 1, 0, 0);

        cur_req = "R8 SE0 right after an end state";
        se0_run(3, 0); put(0, 1, 0, 0); se0_run(3, 0); put(0, 0, 1, 0); se0_run(3, 0); put(0, 1, 0, 0);
        put(0, 1, 0, 0);

        cur_req = "R5 low speed 14 samples";
        low_speed = 1'b1;
        se0_run(LS_LIM - 1, 1); put(0, 1, 0, 1);

        cur_req = "R5 low speed 15 samples";
        se0_run(LS_LIM, 2); put(0, 1, 0, 1); put(0, 1, 0, 1);

        cur_req = "R7 low speed bad end";
        se0_run(LS_LIM + 3, 0); put(0, 0, 1, 0); put(0, 1, 0, 0);

        cur_req = "R9 idle cycles with line noise";
        se0_run(2, 5); put(0, 1, 0, 3);
        low_speed = 1'b0;
        se0_run(FS_LIM, 4); put(0, 1, 0, 4);

        cur_req = "R1 reset mid run";
        se0_run(2, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        put(0, 1, 0, 0);
        se0_run(2, 0); put(0, 1, 0, 0);
        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule